// File: doc/BRIEF.md
# Interrupt-Aware Instruction Cycle Sequencer

This block is the control sequencer of a small processor core. It takes the core through three phases in turn: fetch, execute and interrupt check. On fetch the program counter advances. Execute lasts until the datapath reports that it has finished; in this block a plain `exec_done` input stands in for the datapath. In the interrupt-check phase the sequencer decides whether to leave the running program for a handler.

When it takes a request, it pushes the current program counter and active level onto an internal context stack. It then loads the program counter with the base address given for that request line. A return strobe pops the stack and resumes the interrupted code.

A mode input selects one of two policies. In sequential mode, no request is taken while a handler runs, and waiting requests are served in the order they arrived. In nested mode, a request with a higher line index preempts the running handler, and the return goes back to the preempted handler. The mode is held constant between resets.

Top module: `intr_cycle_seq`

## Requirements
- R1: After synchronous reset: `pc` is 0, `phase` is FETCH (code 0), `act_valid` is 0, and `ctx_save` and `ctx_restore` are low.
- R2: Phase behaviour:
  - FETCH lasts one cycle, adds 1 to `pc` and moves to EXEC (code 1).
  - EXEC holds with `pc` unchanged until `exec_done` is high, then moves to ICHK (code 2).
  - ICHK lasts one cycle, ignores `exec_done` and moves to FETCH.
- R3: When a request is taken in ICHK, three things happen on the next cycle:
  - `pc` equals the base of line i, which is field `hdl_base[i*AW +: AW]`.
  - `act_valid` is 1 and `act_lvl` is i.
  - `ctx_save` pulses for one cycle.
- R4: Return from a handler:
  - `hdl_ret` together with `exec_done` in EXEC, while a context is saved, restores the saved `pc` and level and pulses `ctx_restore`.
  - With no saved context, `hdl_ret` has no effect.
- R5: In sequential mode (`nest_mode`=0), no request is taken while `act_valid` is 1. After the return, waiting lines are taken one per handler in arrival order, whatever their index.
- R6: In nested mode (`nest_mode`=1):
  - A pending line with an index above `act_lvl` preempts the handler.
  - A line at or below `act_lvl` waits.
  - A return resumes the preempted handler with its level.
- R7: A request pulse leaves its line pending until that line is taken. A further pulse on a line that is already pending adds no second service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NLINE | Request pulses, higher index = higher priority |
| nest_mode | input | 1 | 0 sequential policy, 1 nested policy |
| exec_done | input | 1 | Execute phase complete |
| hdl_ret | input | 1 | Return-from-handler strobe |
| hdl_base | input | NLINE*AW | Handler start address per line |
| pc | output | AW | Program counter (next fetch address) |
| phase | output | 2 | 0 FETCH, 1 EXEC, 2 ICHK |
| act_valid | output | 1 | A handler is running |
| act_lvl | output | LW | Line of the running handler |
| ctx_save | output | 1 | Context pushed this cycle |
| ctx_restore | output | 1 | Context popped this cycle |
| stk_err | output | 1 | Push refused because the stack was full |

## Verification
The timing of each result is fixed:

| Result | Appears |
|---|---|
| Fetch increment, phase move | At the next edge |
| Pending bit from a request pulse | One edge after the pulse |
| Take (new `pc`, level, `ctx_save`) | At the edge that ends ICHK |
| Restore (`pc`, level, `ctx_restore`) | At the edge that ends EXEC |
| Next take after a restore | Exactly one edge after the restore |

The bench drives inputs and samples outputs on the falling edge. Each check is read one sample after the edge that produces its result. The saved address is taken from the sample just before the take.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_ICHK  = 2'd2
  } phase_t;
endpackage

// File: rtl/isq_pend.sv
// Pending request tracking, arrival-order queue and candidate selection.
module isq_pend #(
  parameter int NLINE = 4,
  parameter int LW    = $clog2(NLINE),
  parameter int CW    = $clog2(NLINE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINE-1:0] irq_req,
  input  logic             nest_mode,
  input  logic             act_valid,
  input  logic [LW-1:0]    act_lvl,
  input  logic             accept,
  output logic             cand_ok,
  output logic [LW-1:0]    cand_lvl
);
  logic [NLINE-1:0] pend;
  logic [NLINE-1:0] clr_vec;
  logic [NLINE-1:0] new_req;
  logic [LW-1:0]    q  [NLINE];
  logic [LW-1:0]    qn [NLINE];
  logic [CW-1:0]    cnt, cn;
  logic [LW-1:0]    hi_lvl;
  logic             hi_any;

  // candidate selection: queue head (sequential) or highest pending (nested)
  always_comb begin
    hi_any = 1'b0;
    hi_lvl = '0;
    for (int i = 0; i < NLINE; i++) begin
      if (pend[i]) begin
        hi_any = 1'b1;
        hi_lvl = LW'(i);
      end
    end
    if (nest_mode) begin
      cand_lvl = hi_lvl;
      cand_ok  = hi_any && (!act_valid || (hi_lvl > act_lvl));
    end else begin
      cand_lvl = q[0];
      cand_ok  = (cnt != '0) && !act_valid;
    end
  end

  always_comb begin
    clr_vec = '0;
    if (accept) clr_vec[cand_lvl] = 1'b1;
    new_req = irq_req & ~(pend & ~clr_vec) & {NLINE{!nest_mode}};
  end

  // next queue contents: drop head on accept, then append newcomers
  always_comb begin
    for (int i = 0; i < NLINE; i++) qn[i] = q[i];
    cn = cnt;
    if (accept && !nest_mode && (cnt != '0)) begin
      for (int i = 0; i < NLINE - 1; i++) qn[i] = q[i+1];
      cn = cnt - 1'b1;
    end
    for (int i = NLINE - 1; i >= 0; i--) begin
      if (new_req[i] && (cn < CW'(NLINE))) begin
        qn[cn[LW-1:0]] = LW'(i);
        cn = cn + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      cnt  <= '0;
      for (int i = 0; i < NLINE; i++) q[i] <= '0;
    end else begin
      pend <= (pend & ~clr_vec) | irq_req;
      cnt  <= cn;
      for (int i = 0; i < NLINE; i++) q[i] <= qn[i];
    end
  end
endmodule

// File: rtl/isq_stack.sv
// Context stack: saved program counter, valid flag and level.
module isq_stack #(
  parameter int DEPTH = 4,
  parameter int DW    = 19,
  parameter int AW_S  = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] sp;
  logic [CW-1:0] sp_m1;

  assign sp_m1 = sp - 1'b1;
  assign empty = (sp == '0);
  assign full  = (sp == CW'(DEPTH));
  assign rdata = mem[sp_m1[AW_S-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[sp[AW_S-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push && !full) sp <= sp + 1'b1;
    else if (pop && !empty) sp <= sp_m1;
  end
endmodule

// File: rtl/intr_cycle_seq.sv
module intr_cycle_seq #(
  parameter int NLINE = 4,
  parameter int AW    = 16,
  parameter int LW    = $clog2(NLINE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NLINE-1:0]    irq_req,
  input  logic                nest_mode,
  input  logic                exec_done,
  input  logic                hdl_ret,
  input  logic [NLINE*AW-1:0] hdl_base,
  output logic [AW-1:0]       pc,
  output logic [1:0]          phase,
  output logic                act_valid,
  output logic [LW-1:0]       act_lvl,
  output logic                ctx_save,
  output logic                ctx_restore,
  output logic                stk_err
);
  import isq_pkg::*;

  localparam int DW = AW + 1 + LW;

  phase_t        ph;
  logic          cand_ok;
  logic [LW-1:0] cand_lvl;
  logic          push, pop, stk_empty, stk_full;
  logic [DW-1:0] stk_wdata, stk_rdata;

  assign phase     = ph;
  assign push      = (ph == PH_ICHK) && cand_ok && !stk_full;
  assign pop       = (ph == PH_EXEC) && exec_done && hdl_ret && !stk_empty;
  assign stk_wdata = {pc, act_valid, act_lvl};

  isq_pend #(.NLINE(NLINE)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .nest_mode (nest_mode),
    .act_valid (act_valid),
    .act_lvl   (act_lvl),
    .accept    (push),
    .cand_ok   (cand_ok),
    .cand_lvl  (cand_lvl)
  );

  isq_stack #(.DEPTH(NLINE), .DW(DW)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .wdata (stk_wdata),
    .rdata (stk_rdata),
    .empty (stk_empty),
    .full  (stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_FETCH;
      pc          <= '0;
      act_valid   <= 1'b0;
      act_lvl     <= '0;
      ctx_save    <= 1'b0;
      ctx_restore <= 1'b0;
      stk_err     <= 1'b0;
    end else begin
      ctx_save    <= 1'b0;
      ctx_restore <= 1'b0;
      stk_err     <= 1'b0;
      case (ph)
        PH_FETCH: begin
          pc <= pc + 1'b1;
          ph <= PH_EXEC;
        end
        PH_EXEC: begin
          if (exec_done) begin
            ph <= PH_ICHK;
            if (pop) begin
              {pc, act_valid, act_lvl} <= stk_rdata;
              ctx_restore              <= 1'b1;
            end
          end
        end
        PH_ICHK: begin
          ph <= PH_FETCH;
          if (cand_ok) begin
            if (stk_full) begin
              stk_err <= 1'b1;
            end else begin
              pc        <= hdl_base[cand_lvl*AW +: AW];
              act_valid <= 1'b1;
              act_lvl   <= cand_lvl;
              ctx_save  <= 1'b1;
            end
          end
        end
        default: ph <= PH_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/isq_chk.sv
module isq_chk #(
  parameter int NLINE = 4,
  parameter int AW    = 16,
  parameter int LW    = $clog2(NLINE)
) (
  input logic          clk,
  input logic          rst,
  input logic          nest_mode,
  input logic          exec_done,
  input logic [AW-1:0] pc,
  input logic [1:0]    phase,
  input logic          act_valid,
  input logic [LW-1:0] act_lvl,
  input logic          ctx_save,
  input logic          ctx_restore
);
  p_fetch_adv_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0) |=> (phase == 2'd1) && (pc == $past(pc) + 1'b1));

  p_exec_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && !exec_done) |=> (phase == 2'd1) && $stable(pc));

  p_ichk_next_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2) |=> (phase == 2'd0));

  p_save_active_r3: assert property (@(posedge clk) disable iff (rst)
    ctx_save |-> act_valid && (phase == 2'd0));

  p_restore_after_exec_r4: assert property (@(posedge clk) disable iff (rst)
    ctx_restore |-> (phase == 2'd2) && !ctx_save);

  p_seq_no_take_r5: assert property (@(posedge clk) disable iff (rst)
    (!nest_mode && act_valid && phase == 2'd2) |=> !ctx_save);

  p_nest_higher_r6: assert property (@(posedge clk) disable iff (rst)
    (nest_mode && act_valid && phase == 2'd2) |=> (!ctx_save || act_lvl > $past(act_lvl)));
endmodule

bind intr_cycle_seq isq_chk #(.NLINE(NLINE), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .nest_mode   (nest_mode),
  .exec_done   (exec_done),
  .pc          (pc),
  .phase       (phase),
  .act_valid   (act_valid),
  .act_lvl     (act_lvl),
  .ctx_save    (ctx_save),
  .ctx_restore (ctx_restore)
);

// File: tb/intr_cycle_seq_tb.sv
module intr_cycle_seq_tb;
  localparam int CLK_P = 10;
  localparam int NLINE = 4;
  localparam int AW    = 16;
  localparam int LW    = 2;
  localparam int NROW  = 10;
  // row: {exec_done, expected pc, expected phase}
  localparam logic [18:0] TBL [NROW] = '{
    {1'b0, 16'd1, 2'd1}, {1'b0, 16'd1, 2'd1}, {1'b1, 16'd1, 2'd2},
    {1'b1, 16'd1, 2'd0}, {1'b1, 16'd2, 2'd1}, {1'b1, 16'd2, 2'd2},
    {1'b0, 16'd2, 2'd0}, {1'b0, 16'd3, 2'd1}, {1'b1, 16'd3, 2'd2},
    {1'b1, 16'd3, 2'd0}};

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NLINE-1:0]    irq_req = '0;
  logic                nest_mode = 1'b0;
  logic                exec_done = 1'b0;
  logic                hdl_ret = 1'b0;
  logic [NLINE*AW-1:0] hdl_base;
  logic [AW-1:0]       pc;
  logic [1:0]          phase;
  logic                act_valid;
  logic [LW-1:0]       act_lvl;
  logic                ctx_save, ctx_restore, stk_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW-1:0] last_pc = '0;
  logic [AW-1:0] sv0, sv1;
  int saves, rests;

  always #(CLK_P/2) clk = ~clk;

  assign hdl_base = {16'h0400, 16'h0300, 16'h0200, 16'h0100};

  intr_cycle_seq #(.NLINE(NLINE), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nest_mode(nest_mode),
    .exec_done(exec_done), .hdl_ret(hdl_ret), .hdl_base(hdl_base),
    .pc(pc), .phase(phase), .act_valid(act_valid), .act_lvl(act_lvl),
    .ctx_save(ctx_save), .ctx_restore(ctx_restore), .stk_err(stk_err));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    last_pc = pc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int line);
    irq_req = '0;
    irq_req[line] = 1'b1;
    tick();
    irq_req = '0;
  endtask

  task automatic wait_save(output logic [AW-1:0] saved);
    saved = '0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (ctx_save) begin
        saved = last_pc;
        break;
      end
    end
  endtask

  task automatic do_ret();
    hdl_ret = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (ctx_restore) break;
    end
    hdl_ret = 1'b0;
  endtask

  task automatic run_count(input int n);
    saves = 0;
    rests = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (ctx_save) saves++;
      if (ctx_restore) rests++;
    end
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    nest_mode = mode;
    tick();
    tick();
    rst = 1'b0;
    chk(pc == 0 && phase == 2'd0, "R1 reset pc/phase", {pc, phase}, 0);
    chk(!act_valid && !ctx_save && !ctx_restore, "R1 reset flags",
        {act_valid, ctx_save, ctx_restore}, 0);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    // R2: phase walk from the table
    for (int r = 0; r < NROW; r++) begin
      exec_done = TBL[r][18];
      tick();
      chk(pc == TBL[r][17:2] && phase == TBL[r][1:0], "R2 phase table",
          {pc, phase}, {TBL[r][17:2], TBL[r][1:0]});
    end
    exec_done = 1'b1;

    // sequential policy
    pulse(1);
    wait_save(sv0);
    chk(pc == 16'h0200 && act_lvl == 1 && act_valid, "R3 take line1", pc, 16'h0200);
    pulse(3);
    tick();
    pulse(2);
    pulse(2);
    run_count(6);
    chk(saves == 0 && act_lvl == 1, "R5 no take while active", saves, 0);
    do_ret();
    chk(pc == sv0 && !act_valid, "R4 restore to program", pc, sv0);
    tick();
    chk(ctx_save && pc == 16'h0400 && act_lvl == 3, "R5 arrival order first line3", pc, 16'h0400);
    do_ret();
    chk(pc == sv0, "R4 restore second", pc, sv0);
    tick();
    chk(ctx_save && pc == 16'h0300 && act_lvl == 2, "R5 arrival order then line2", pc, 16'h0300);
    do_ret();
    chk(pc == sv0 && !act_valid, "R4 restore third", pc, sv0);
    run_count(9);
    chk(saves == 0, "R7 repeated pulse served once", saves, 0);
    hdl_ret = 1'b1;
    run_count(9);
    hdl_ret = 1'b0;
    chk(rests == 0 && !act_valid, "R4 return with empty stack ignored", rests, 0);

    // nested policy
    do_reset(1'b1);
    pulse(1);
    wait_save(sv0);
    chk(pc == 16'h0200 && act_lvl == 1, "R3 nested take line1", pc, 16'h0200);
    pulse(0);
    pulse(1);
    run_count(9);
    chk(saves == 0 && act_lvl == 1, "R6 at or below waits", saves, 0);
    pulse(2);
    wait_save(sv1);
    chk(pc == 16'h0300 && act_lvl == 2, "R6 preempt by line2", pc, 16'h0300);
    do_ret();
    chk(pc == sv1 && act_valid && act_lvl == 1, "R6 resume preempted handler", pc, sv1);
    run_count(6);
    chk(saves == 0, "R6 lower waits after resume", saves, 0);
    do_ret();
    chk(pc == sv0 && !act_valid, "R4 nested restore to program", pc, sv0);
    tick();
    chk(ctx_save && pc == 16'h0200 && act_lvl == 1, "R7 pending line1 kept", pc, 16'h0200);
    do_ret();
    tick();
    chk(ctx_save && pc == 16'h0100 && act_lvl == 0, "R7 pending line0 kept", pc, 16'h0100);
    finish_up();
  end
endmodule